// File: doc/BRIEF.md
# Legacy BIOS Region Shadow Router

This block decides, for each CPU memory transaction, whether it is served by local DRAM or forwarded to the downstream link, where the boot ROM lives. Only the legacy BIOS window from 0x000C_0000 to 0x000F_FFFF is steered. That window is cut into sixteen 16 KB segments. Each segment holds two attribute bits. One says that reads of the segment come from DRAM. The other says that writes to the segment go to DRAM.

Firmware uses the block to shadow ROM. It first sets a segment so that reads go to the link and writes go to DRAM. It copies the ROM contents over itself, so the bytes are read from ROM and written into DRAM. It then sets the segment so that reads are served from DRAM. After that, code runs from the faster DRAM copy.

The attributes are loaded through a simple write port, one segment per cycle. A routing decision appears one clock after the transaction is presented. Addresses outside the window get no routing decision and are marked as out of range.

Top module: `shadow_route`

## Requirements
- R1: After reset, `res_valid` is low and every segment's read and write attribute bits are 0. Until they are reprogrammed, every in-range read and write goes to the link (`res_to_link`=1, `res_to_dram`=0). A reset in mid-run clears all attributes again.
- R2: An in-range read (`txn_write`=0) sets `res_to_dram` when the read attribute of its segment is 1, and sets `res_to_link` when that attribute is 0.
- R3: An in-range write (`txn_write`=1) sets `res_to_dram` when the write attribute of its segment is 1, and sets `res_to_link` when that attribute is 0.
- R4: Reads and writes are steered independently. With the read attribute at 0 and the write attribute at 1 (copy phase), a read of a segment goes to the link while a write to the same segment goes to DRAM. With the read attribute at 1 and the write attribute at 0, the routes reverse.
- R5: An address below 0x000C_0000 or above 0x000F_FFFF, including one that differs only in upper address bits, gives `res_in_range`=0, `res_to_dram`=0 and `res_to_link`=0, with `res_valid`=1.
- R6: The segment index is (addr − 0x000C_0000) >> 14, giving indices 0 to 15. 0x000C_3FFF falls in segment 0, 0x000C_4000 falls in segment 1, and 0x000F_FFFF falls in segment 15. A write to one segment's attributes leaves every other segment unchanged.
- R7: An attribute write presented on `attr_we` at a clock edge does not affect a transaction captured at that same edge. It does affect every transaction captured at a later edge.
- R8: The result is registered. `res_valid` is high in the cycle after `txn_valid` was sampled high. For an in-range transaction, exactly one of `res_to_dram` and `res_to_link` is 1.
- R9: In a cycle after `txn_valid` was sampled low, all four result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | CPU memory transaction present this cycle |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_addr | input | 32 | Byte address of the transaction |
| attr_we | input | 1 | Load the attribute bits of one segment |
| attr_seg | input | 4 | Segment whose attributes are loaded |
| attr_rd_dram | input | 1 | New read attribute: 1 = reads served by DRAM |
| attr_wr_dram | input | 1 | New write attribute: 1 = writes land in DRAM |
| res_valid | output | 1 | Routing result valid, one cycle after the transaction |
| res_in_range | output | 1 | Transaction fell inside the shadowed window |
| res_to_dram | output | 1 | Route transaction to DRAM |
| res_to_link | output | 1 | Route transaction to the downstream link |

## Verification
The bench loads a mixed attribute pattern across all sixteen segments. It then hits segment first and last bytes, so a design that computed the segment index from the wrong bit field, or off by one, would route 0x000C_4000 or 0x000F_FFFF by the wrong segment's bits.

It also probes the edges of the window:
- 0x000B_FFFF, just below the window;
- 0x0010_0000, just above it;
- an address whose upper bits alone are outside the window.

A range check that ignored the upper bits, or was off by one, would return a DRAM or link route for one of these.

Two directed sequences finish the checks. The copy-phase sequence catches a design that applied the read bit to writes. The write-and-transaction-in-the-same-cycle case catches a design that bypassed the new attribute into the current decision.

// File: rtl/shdw_pkg.sv
package shdw_pkg;

    localparam int unsigned SHD_ADDR_W   = 32;
    localparam int unsigned SHD_SEGS     = 16;
    localparam int unsigned SHD_SEG_LOG2 = 14;
    localparam logic [31:0] SHD_BASE     = 32'h000C_0000;

    // Registered routing decision
    typedef struct packed {
        logic valid;
        logic in_range;
        logic to_dram;
        logic to_link;
    } route_res_t;

    localparam route_res_t ROUTE_IDLE = '{valid: 1'b0, in_range: 1'b0,
                                          to_dram: 1'b0, to_link: 1'b0};

    // Pick the attribute bit that governs this transaction direction
    function automatic logic pick_attr(input logic is_write,
                                       input logic rd_bit,
                                       input logic wr_bit);
        return is_write ? wr_bit : rd_bit;
    endfunction

endpackage

// File: rtl/shdw_attr_regs.sv
module shdw_attr_regs #(
    parameter int unsigned SEGS  = shdw_pkg::SHD_SEGS,
    localparam int unsigned IDX_W = $clog2(SEGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] seg,
    input  logic             rd_dram,
    input  logic             wr_dram,
    output logic [SEGS-1:0]  rd_mask,
    output logic [SEGS-1:0]  wr_mask
);

    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_mask[g] <= 1'b0;
                wr_mask[g] <= 1'b0;
            end else if (we && (seg == IDX_W'(g))) begin
                rd_mask[g] <= rd_dram;
                wr_mask[g] <= wr_dram;
            end
        end
    end

    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(rd_mask) && $stable(wr_mask))); // R7

endmodule

// File: rtl/shdw_seg_decode.sv
module shdw_seg_decode #(
    parameter int unsigned ADDR_W   = shdw_pkg::SHD_ADDR_W,
    parameter int unsigned SEGS     = shdw_pkg::SHD_SEGS,
    parameter int unsigned SEG_LOG2 = shdw_pkg::SHD_SEG_LOG2,
    parameter logic [31:0] BASE     = shdw_pkg::SHD_BASE,
    localparam int unsigned IDX_W   = $clog2(SEGS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [IDX_W-1:0]  seg
);

    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(SEGS) << SEG_LOG2;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset   = addr - BASE_V;
        in_range = (addr >= BASE_V) && (offset < SPAN_V);
        seg      = offset[SEG_LOG2 +: IDX_W];
    end

endmodule

// File: rtl/shdw_route_sel.sv
module shdw_route_sel
    import shdw_pkg::*;
#(
    parameter int unsigned SEGS  = SHD_SEGS,
    localparam int unsigned IDX_W = $clog2(SEGS)
) (
    input  logic             valid,
    input  logic             is_write,
    input  logic             in_range,
    input  logic [IDX_W-1:0] seg,
    input  logic [SEGS-1:0]  rd_mask,
    input  logic [SEGS-1:0]  wr_mask,
    output route_res_t       res
);

    logic use_dram;

    always_comb begin
        use_dram     = pick_attr(is_write, rd_mask[seg], wr_mask[seg]);
        res          = ROUTE_IDLE;
        res.valid    = valid;
        res.in_range = valid && in_range;
        res.to_dram  = valid && in_range && use_dram;
        res.to_link  = valid && in_range && !use_dram;
    end

endmodule

// File: rtl/shadow_route.sv
module shadow_route
    import shdw_pkg::*;
#(
    parameter int unsigned ADDR_W   = SHD_ADDR_W,
    parameter int unsigned SEGS     = SHD_SEGS,
    parameter int unsigned SEG_LOG2 = SHD_SEG_LOG2,
    parameter logic [31:0] BASE     = SHD_BASE,
    localparam int unsigned IDX_W   = $clog2(SEGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_valid,
    input  logic              txn_write,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              attr_we,
    input  logic [IDX_W-1:0]  attr_seg,
    input  logic              attr_rd_dram,
    input  logic              attr_wr_dram,
    output logic              res_valid,
    output logic              res_in_range,
    output logic              res_to_dram,
    output logic              res_to_link
);

    logic [SEGS-1:0]  rd_mask;
    logic [SEGS-1:0]  wr_mask;
    logic             dec_in_range;
    logic [IDX_W-1:0] dec_seg;
    route_res_t       res_d;
    route_res_t       res_q;

    shdw_attr_regs #(.SEGS(SEGS)) attr_i (
        .clk     (clk),
        .rst     (rst),
        .we      (attr_we),
        .seg     (attr_seg),
        .rd_dram (attr_rd_dram),
        .wr_dram (attr_wr_dram),
        .rd_mask (rd_mask),
        .wr_mask (wr_mask)
    );

    shdw_seg_decode #(
        .ADDR_W   (ADDR_W),
        .SEGS     (SEGS),
        .SEG_LOG2 (SEG_LOG2),
        .BASE     (BASE)
    ) dec_i (
        .addr     (txn_addr),
        .in_range (dec_in_range),
        .seg      (dec_seg)
    );

    shdw_route_sel #(.SEGS(SEGS)) sel_i (
        .valid    (txn_valid),
        .is_write (txn_write),
        .in_range (dec_in_range),
        .seg      (dec_seg),
        .rd_mask  (rd_mask),
        .wr_mask  (wr_mask),
        .res      (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= ROUTE_IDLE;
        else     res_q <= res_d;
    end

    assign res_valid    = res_q.valid;
    assign res_in_range = res_q.in_range;
    assign res_to_dram  = res_q.to_dram;
    assign res_to_link  = res_q.to_link;

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> res_valid); // R8
    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_in_range) |-> (res_to_dram ^ res_to_link)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !txn_valid |=> !(res_valid || res_in_range || res_to_dram || res_to_link)); // R9
    AST_OUT_RANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_in_range) |-> !(res_to_dram || res_to_link)); // R5
    AST_READ_DRAM: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_write && dec_in_range && rd_mask[dec_seg]) |=> res_to_dram); // R2
    AST_WRITE_DRAM: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_write && dec_in_range && wr_mask[dec_seg]) |=> res_to_dram); // R3

endmodule

// File: tb/shadow_route_tb.sv
module shadow_route_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_valid = 1'b0, txn_write = 1'b0;
    logic [31:0] txn_addr = '0;
    logic        attr_we = 1'b0, attr_rd_dram = 1'b0, attr_wr_dram = 1'b0;
    logic [3:0]  attr_seg = '0;
    logic        res_valid, res_in_range, res_to_dram, res_to_link;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shadow_route dut_i (.*);

    localparam logic [15:0] RD_PAT = 16'hA5C3;
    localparam logic [15:0] WR_PAT = 16'h3C5A;

    // {write, addr, exp_in_range, exp_dram}; link expected = in_range & !dram
    localparam int NV = 14;
    localparam logic [34:0] VECS [NV] = '{
        {1'b0, 32'h000C_0000, 1'b1, 1'b1},
        {1'b1, 32'h000C_0000, 1'b1, 1'b0},
        {1'b0, 32'h000C_4000, 1'b1, 1'b1},
        {1'b1, 32'h000C_7FFF, 1'b1, 1'b1},
        {1'b0, 32'h000C_8000, 1'b1, 1'b0},
        {1'b1, 32'h000C_C010, 1'b1, 1'b1},
        {1'b0, 32'h000C_FFFF, 1'b1, 1'b0},
        {1'b0, 32'h000F_C000, 1'b1, 1'b1},
        {1'b1, 32'h000F_FFFF, 1'b1, 1'b0},
        {1'b1, 32'h000F_0000, 1'b1, 1'b1},
        {1'b0, 32'h000F_3FFF, 1'b1, 1'b0},
        {1'b0, 32'h000B_FFFF, 1'b0, 1'b0},
        {1'b1, 32'h0010_0000, 1'b0, 1'b0},
        {1'b0, 32'h100C_0000, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,in,dram,link} got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {res_valid, res_in_range, res_to_dram, res_to_link};
    endfunction

    task automatic set_attr(input int seg, input logic rd, input logic wr);
        @(negedge clk);
        attr_we = 1'b1; attr_seg = 4'(seg); attr_rd_dram = rd; attr_wr_dram = wr;
        @(negedge clk);
        attr_we = 1'b0;
    endtask

    // Present one transaction, check result one cycle later
    task automatic txn(input string tag, input logic wr, input logic [31:0] a,
                       input logic exp_in, input logic exp_dram);
        @(negedge clk);
        txn_valid = 1'b1; txn_write = wr; txn_addr = a;
        @(negedge clk);
        txn_valid = 1'b0;
        check(tag, outs(), {1'b1, exp_in, exp_in & exp_dram, exp_in & ~exp_dram});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset outputs", outs(), 4'b0000);
        txn("R1 reset read link", 1'b0, 32'h000C_0000, 1'b1, 1'b0);
        txn("R1 reset write link", 1'b1, 32'h000E_0000, 1'b1, 1'b0);

        for (int s = 0; s < 16; s++) set_attr(s, RD_PAT[s], WR_PAT[s]);

        for (int i = 0; i < NV; i++) begin
            // R2 R3 R5 R6 R8 table walk
            txn($sformatf("R2/R3/R5/R6 vec %0d", i), VECS[i][34], VECS[i][33:2],
                VECS[i][1], VECS[i][0]);
        end

        @(negedge clk);
        check("R9 idle outputs", outs(), 4'b0000);

        // R4 copy phase then shadowed phase on segment 7 (0x000DC000)
        set_attr(7, 1'b0, 1'b1);
        txn("R4 copy read link", 1'b0, 32'h000D_C000, 1'b1, 1'b0);
        txn("R4 copy write dram", 1'b1, 32'h000D_C000, 1'b1, 1'b1);
        set_attr(7, 1'b1, 1'b0);
        txn("R4 shadow read dram", 1'b0, 32'h000D_C100, 1'b1, 1'b1);
        txn("R4 shadow write link", 1'b1, 32'h000D_C100, 1'b1, 1'b0);

        // R7 attribute write and transaction at the same edge (seg 5, rd was 0)
        @(negedge clk);
        attr_we = 1'b1; attr_seg = 4'd5; attr_rd_dram = 1'b1; attr_wr_dram = 1'b0;
        txn_valid = 1'b1; txn_write = 1'b0; txn_addr = 32'h000D_4000;
        @(negedge clk);
        attr_we = 1'b0; txn_valid = 1'b0;
        check("R7 same edge uses old", outs(), 4'b1101);
        txn("R7 next uses new", 1'b0, 32'h000D_4000, 1'b1, 1'b1);
        // R6 neighbours untouched
        txn("R6 seg4 unchanged", 1'b0, 32'h000D_0000, 1'b1, 1'b0);
        txn("R6 seg6 unchanged", 1'b0, 32'h000D_8000, 1'b1, 1'b1);

        // R1 mid-run reset clears attributes
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 mid reset outputs", outs(), 4'b0000);
        txn("R1 cleared read seg0", 1'b0, 32'h000C_0000, 1'b1, 1'b0);
        txn("R1 cleared write seg1", 1'b1, 32'h000C_4000, 1'b1, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule